// File: doc/BRIEF.md
# Speculative Two-Phase Adder

This block adds two BITS-wide operands and a carry-in without waiting for the carry to ripple across the full width. The sum is split into a lower half and an upper half. The lower half adds its operand slices together with the external carry-in. The upper half does not wait for the lower carry. It starts at once with a predicted carry-in, which is the AND of the two operand bits at the top position of the lower half.

When the prediction agrees with the real carry out of the lower half, the result is registered one cycle after the operands were taken. When it disagrees, the block spends one more cycle. It recomputes the upper half with the opposite carry-in, which is then certain to be right. Latency therefore depends on the data and is either one or two cycles.

Operands enter through a valid/ready handshake. The result is presented as a level that stays valid until the next operand set is taken. A saturating counter reports how many predictions have missed since reset.

Top module: `spec_carry_adder`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `res_valid` is 0, `in_ready` is 1 and `miss_count` is 0.
- R2: An operand set is taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the result for that set has been registered.
- R3: The registered result satisfies {`res_cout`, `res_sum`} == `in_a` + `in_b` + `in_cin`, evaluated as an unsigned BITS+1-bit value.
- R4: The predicted carry is `in_a[BITS/2-1] & in_b[BITS/2-1]`. When it equals the true carry out of bits [BITS/2-1:0] plus `in_cin`, `res_valid` rises at the first edge after the take edge.
- R5: When the prediction differs from the true lower carry, `res_valid` stays 0 for one extra cycle and rises at the second edge after the take edge.
- R6: Once `res_valid` is 1, it and `res_sum`/`res_cout` hold their values until the next take edge. `res_valid` falls at that take edge.
- R7: `miss_count` grows by exactly one for each mispredicted operand set, and it stays at all ones once it gets there (width MISS_W).
- R8: `in_valid` and operand values presented while `in_ready` is 0 have no effect on the result or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set (idle) |
| in_a | input | BITS | First operand |
| in_b | input | BITS | Second operand |
| in_cin | input | 1 | Carry-in |
| res_valid | output | 1 | Result registered and held |
| res_sum | output | BITS | Sum |
| res_cout | output | 1 | Carry-out of the full width |
| miss_count | output | MISS_W | Saturating count of mispredictions |

## Verification
The bench goes after operands whose top lower-half bits differ, because that is where the prediction fails. Examples are a lower half of all ones plus one, and a carry-in that alone pushes the lower half over. A design that took the wrong upper carry would return a sum off by 2^(BITS/2) with the wrong carry-out. A design that retried too late or not at all would show a one-cycle latency on a miss, or a two-cycle latency on a hit. The bench also keeps `in_valid` high with changing data while the block is busy. This would corrupt the result or double-count misses in a design that took operands while not ready. It drives enough misses to show that the counter sticks at all ones instead of wrapping to zero.

// File: rtl/spec_add_pkg.sv
package spec_add_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EVAL = 2'd1,
    PH_FIX  = 2'd2
  } phase_t;
endpackage

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar g = 0; g < W; g++) begin : g_cell
    logic p;
    assign p        = x[g] ^ y[g];
    assign s[g]     = p ^ c[g];
    assign c[g+1]   = (x[g] & y[g]) | (p & c[g]);
  end
  assign co = c[W];
endmodule

// File: rtl/spec_datapath.sv
module spec_datapath #(
  parameter int BITS = 16
) (
  input  logic [BITS-1:0] a,
  input  logic [BITS-1:0] b,
  input  logic            cin,
  input  logic            retry,
  output logic [BITS-1:0] sum,
  output logic            cout,
  output logic            hit
);
  localparam int LO_W = BITS / 2;
  localparam int HI_W = BITS - LO_W;

  logic [LO_W-1:0] lo_s;
  logic            lo_c;
  logic [HI_W-1:0] hi_s;
  logic            guess;
  logic            hi_ci;

  // prediction: both top lower-half bits set means a carry is certain
  assign guess = a[LO_W-1] & b[LO_W-1];
  assign hi_ci = retry ? ~guess : guess;

  seg_adder #(.W(LO_W)) u_lo (
    .x(a[LO_W-1:0]), .y(b[LO_W-1:0]), .ci(cin), .s(lo_s), .co(lo_c)
  );
  seg_adder #(.W(HI_W)) u_hi (
    .x(a[BITS-1:LO_W]), .y(b[BITS-1:LO_W]), .ci(hi_ci), .s(hi_s), .co(cout)
  );

  assign sum = {hi_s, lo_s};
  assign hit = (guess == lo_c);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/spec_carry_adder.sv
module spec_carry_adder
  import spec_add_pkg::*;
#(
  parameter int BITS   = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BITS-1:0]   in_a,
  input  logic [BITS-1:0]   in_b,
  input  logic              in_cin,
  output logic              res_valid,
  output logic [BITS-1:0]   res_sum,
  output logic              res_cout,
  output logic [MISS_W-1:0] miss_count
);
  phase_t          phase;
  logic [BITS-1:0] op_a, op_b;
  logic            op_c;
  logic [BITS-1:0] dp_sum;
  logic            dp_cout;
  logic            spec_hit;
  logic            miss_inc;

  assign in_ready = (phase == PH_IDLE);
  assign miss_inc = (phase == PH_EVAL) && !spec_hit;

  spec_datapath #(.BITS(BITS)) u_dp (
    .a(op_a), .b(op_b), .cin(op_c), .retry(phase == PH_FIX),
    .sum(dp_sum), .cout(dp_cout), .hit(spec_hit)
  );

  sat_counter #(.W(MISS_W)) u_miss (
    .clk(clk), .rst(rst), .inc(miss_inc), .count(miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      op_a      <= '0;
      op_b      <= '0;
      op_c      <= 1'b0;
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_cout  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (in_valid) begin
          op_a      <= in_a;
          op_b      <= in_b;
          op_c      <= in_cin;
          res_valid <= 1'b0;
          phase     <= PH_EVAL;
        end
        PH_EVAL: if (spec_hit) begin
          res_sum   <= dp_sum;
          res_cout  <= dp_cout;
          res_valid <= 1'b1;
          phase     <= PH_IDLE;
        end else begin
          phase     <= PH_FIX;
        end
        PH_FIX: begin
          res_sum   <= dp_sum;
          res_cout  <= dp_cout;
          res_valid <= 1'b1;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spec_carry_adder_chk.sv
module spec_carry_adder_chk #(
  parameter int BITS   = 16,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic [BITS-1:0]   res_sum,
  input logic              res_cout,
  input logic [MISS_W-1:0] miss_count,
  input logic [1:0]        phase,
  input logic              spec_hit
);
  logic take;
  assign take = in_valid && in_ready;

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready);

  // R6
  valid_drops_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !res_valid);

  // R4
  hit_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && spec_hit) |=> (res_valid && in_ready));

  // R5
  miss_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && !spec_hit) |=> (!res_valid && !in_ready));

  // R5
  retry_finishes_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |=> res_valid);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !take) |=> (res_valid && $stable(res_sum) && $stable(res_cout)));

  // R7
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && !spec_hit && miss_count != '1)
      |=> miss_count == MISS_W'($past(miss_count) + 1'b1));

  // R7
  miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_count == '1) |=> (miss_count == '1));
endmodule

bind spec_carry_adder spec_carry_adder_chk #(.BITS(BITS), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_sum(res_sum), .res_cout(res_cout),
  .miss_count(miss_count), .phase(phase), .spec_hit(spec_hit)
);

// File: tb/spec_carry_adder_test.sv
`timescale 1ns/1ps
module spec_carry_adder_test;
  localparam int BITS   = 16;
  localparam int LO     = BITS / 2;
  localparam int MISS_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [BITS-1:0]   in_a = '0;
  logic [BITS-1:0]   in_b = '0;
  logic              in_cin = 1'b0;
  logic              res_valid;
  logic [BITS-1:0]   res_sum;
  logic              res_cout;
  logic [MISS_W-1:0] miss_count;

  always #10 clk = ~clk;  // 50 MHz

  spec_carry_adder #(.BITS(BITS), .MISS_W(MISS_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .res_valid(res_valid), .res_sum(res_sum), .res_cout(res_cout),
    .miss_count(miss_count)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string cur_tag = "R3";

  // behavioural reference: 0 idle, 1 first try, 2 retry
  int          m_phase = 0;
  bit          m_done  = 0;
  int unsigned m_a = 0, m_b = 0, m_c = 0;
  int unsigned m_res = 0;
  int unsigned m_miss = 0;
  localparam int unsigned MISS_MAX = (1 << MISS_W) - 1;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_phase = 0; m_done = 0; m_miss = 0; m_res = 0;
    end else begin
      case (m_phase)
        0: if (in_valid) begin
          m_a = in_a; m_b = in_b; m_c = in_cin; m_done = 0; m_phase = 1;
        end
        1: begin
          int unsigned low_total;
          bit pred, real_c;
          low_total = (m_a % (1 << LO)) + (m_b % (1 << LO)) + m_c;
          real_c    = (low_total >= (1 << LO));
          pred      = ((m_a >> (LO-1)) & 1) && ((m_b >> (LO-1)) & 1);
          if (pred == real_c) begin
            m_res = m_a + m_b + m_c; m_done = 1; m_phase = 0;
          end else begin
            if (m_miss < MISS_MAX) m_miss++;
            m_phase = 2;
          end
        end
        default: begin
          m_res = m_a + m_b + m_c; m_done = 1; m_phase = 0;
        end
      endcase
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    string t;
    vectors++;
    t = rst ? "R1" : "R2";
    if (in_ready !== (m_phase == 0)) begin
      errors++;
      $display("FAIL %s in_ready actual %0b expected %0b", t, in_ready, (m_phase == 0));
    end
    t = rst ? "R1" : "R4/R5";
    if (res_valid !== m_done) begin
      errors++;
      $display("FAIL %s res_valid actual %0b expected %0b", t, res_valid, m_done);
    end
    if (m_done && {res_cout, res_sum} !== (BITS+1)'(m_res)) begin
      errors++;
      $display("FAIL %s result actual %h expected %h", cur_tag, {res_cout, res_sum}, (BITS+1)'(m_res));
    end
    t = rst ? "R1" : "R7";
    if (miss_count !== MISS_W'(m_miss)) begin
      errors++;
      $display("FAIL %s miss_count actual %0d expected %0d", t, miss_count, m_miss);
    end
  end

  task automatic send(input logic [BITS-1:0] a, input logic [BITS-1:0] b,
                      input logic c, input bit junk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_cin = c;
    @(negedge clk);
    while (!in_ready) begin
      in_valid = junk;   // R8: offered while busy, must be ignored
      if (junk) begin
        in_a = BITS'($urandom); in_b = BITS'($urandom); in_cin = 1'($urandom);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 corner operands
    cur_tag = "R3";
    send(16'h0000, 16'h0000, 1'b0, 0);  // hit
    send(16'h0080, 16'h0080, 1'b0, 0);  // both top low bits set: hit
    send(16'h00FF, 16'h0001, 1'b0, 0);  // miss
    send(16'hFFFF, 16'h0001, 1'b0, 0);  // miss, wraps with carry-out
    send(16'hFFFF, 16'hFFFF, 1'b1, 0);  // hit, all ones out
    send(16'h007F, 16'h0000, 1'b1, 0);  // hit, no low carry
    send(16'h00FF, 16'h0000, 1'b1, 0);  // miss caused by carry-in alone
    send(16'h8000, 16'h8000, 1'b0, 0);  // carry-out only

    // R6 hold: idle gaps with results on display
    cur_tag = "R6";
    send(16'h1234, 16'h4321, 1'b0, 0);
    repeat (5) @(negedge clk);
    send(16'h00C0, 16'h0040, 1'b0, 0);
    repeat (4) @(negedge clk);

    // R8 junk while busy
    cur_tag = "R8";
    for (int i = 0; i < 20; i++)
      send(BITS'($urandom), BITS'($urandom), 1'($urandom), 1);

    // R3 random mix, back-to-back
    cur_tag = "R3";
    for (int i = 0; i < 300; i++)
      send(BITS'($urandom), BITS'($urandom), 1'($urandom), 0);

    // R7 drive misses past saturation
    cur_tag = "R7";
    for (int i = 0; i < 40; i++)
      send(16'h00FF, BITS'(1 + (i % 4)), 1'b0, 0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule